// File: doc/BRIEF.md
# Per-Bank Access Turnaround Timer

This block keeps a minimum idle gap between two accesses to the same memory bank. A DRAM needs this for row precharge, and a slow device needs it to recover after a write. The pattern sequencer reports each microcode word it executes together with the word's bank. When that word is the closing word of an access and also carries the gap flag, the timer for that bank is loaded. While the timer runs, only that bank is reported as blocked. Every other bank can start a new access at once.

Each bank has its own down-counter, so several banks can count at the same time. A 2-bit delay setting is captured when the timer is armed, and a setting of n gives a gap of n+1 cycles. A new request waits while its bank is blocked. The requester keeps the request asserted, and the start strobe rises in the first cycle after the bank's counter reaches zero.

Top module: `bank_gap_timer`

## Requirements
- R1: After reset, no bank is blocked and a request to any bank starts at once.
- R2: A word that carries the gap flag but is not the closing word of its access arms nothing. The flag in that word is ignored.
- R3: A closing word without the gap flag arms nothing.
- R4: A closing word with the gap flag blocks its bank for exactly dly_cfg+1 cycles, counted from the cycle after that word, for every dly_cfg value from 0 to 3.
- R5: Arming one bank never blocks another bank, and requests to other banks start in the same cycle they are presented.
- R6: Banks count independently. A bank armed later with a shorter delay can clear while an earlier bank is still blocked.
- R7: Arming a bank that is already blocked reloads its counter to the full gap, measured from the new closing word.
- R8: rq_go is high exactly when rq_vld is high and the requested bank is not blocked. A request held on a blocked bank starts in the first cycle after that bank's counter reaches zero.
- R9: The delay setting is captured when the timer is armed. Changing dly_cfg while a bank counts does not change that bank's remaining gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| dly_cfg | input | 2 | Delay setting; value n gives n+1 gap cycles |
| wd_vld | input | 1 | A microcode word executes this cycle |
| wd_last | input | 1 | The word closes its access |
| wd_gap | input | 1 | The word requests a turnaround gap |
| wd_bank | input | 2 | Bank of the executing access |
| rq_vld | input | 1 | A new access is waiting to start |
| rq_bank | input | 2 | Bank of the waiting access |
| rq_go | output | 1 | The waiting access may start this cycle |
| bank_blocked | output | 4 | Per-bank blocked indication, bit i for bank i |

## Verification
The assertions check on every cycle that no bank is blocked after reset, that a bank becomes blocked only in the cycle after a qualifying closing word for that bank, that a non-qualifying word leaves an idle bank idle, and that rq_go never rises for a blocked bank. Only the bench scenarios can show the exact length of the gap for each delay setting. The same is true for the reload on re-arm, for the capture of the setting at arming time, for overlapping countdowns on two banks, and for the first cycle in which a held request starts.

// File: rtl/tat_pkg.sv
package tat_pkg;

    parameter int unsigned TAT_BANKS = 4;
    parameter int unsigned TAT_DLY_W = 2;

    // Flags of one executing microcode word
    typedef struct packed {
        logic vld;
        logic last;
        logic gap;
    } word_flags_t;

    // Only a closing word that also asks for a gap arms the timer
    function automatic logic arms_gap(input word_flags_t f);
        return f.vld && f.last && f.gap;
    endfunction

endpackage

// File: rtl/tat_arm_decode.sv
module tat_arm_decode
    import tat_pkg::*;
#(
    parameter int unsigned NBANK  = TAT_BANKS,
    parameter int unsigned DLY_W  = TAT_DLY_W,
    localparam int unsigned BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int unsigned CNT_W  = DLY_W + 1
) (
    input  word_flags_t         flags,
    input  logic [BANK_W-1:0]   bank,
    input  logic [DLY_W-1:0]    dly,
    output logic [NBANK-1:0]    load_vec,
    output logic [CNT_W-1:0]    load_val
);

    logic arm;

    always_comb begin
        arm      = arms_gap(flags);
        load_val = {1'b0, dly} + CNT_W'(1);
        for (int i = 0; i < NBANK; i++) begin
            load_vec[i] = arm && (bank == BANK_W'(i));
        end
    end

endmodule

// File: rtl/tat_bank_cnt.sv
module tat_bank_cnt #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/tat_start_gate.sv
module tat_start_gate #(
    parameter int unsigned NBANK  = 4,
    localparam int unsigned BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic              rq_vld,
    input  logic [BANK_W-1:0] rq_bank,
    input  logic [NBANK-1:0]  blocked,
    output logic              rq_go
);

    always_comb begin
        rq_go = 1'b0;
        for (int i = 0; i < NBANK; i++) begin
            if (rq_bank == BANK_W'(i)) begin
                rq_go = rq_vld && !blocked[i];
            end
        end
    end

endmodule

// File: rtl/bank_gap_timer.sv
module bank_gap_timer
    import tat_pkg::*;
#(
    parameter int unsigned NBANK  = TAT_BANKS,
    parameter int unsigned DLY_W  = TAT_DLY_W,
    localparam int unsigned BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int unsigned CNT_W  = DLY_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DLY_W-1:0]  dly_cfg,
    input  logic              wd_vld,
    input  logic              wd_last,
    input  logic              wd_gap,
    input  logic [BANK_W-1:0] wd_bank,
    input  logic              rq_vld,
    input  logic [BANK_W-1:0] rq_bank,
    output logic              rq_go,
    output logic [NBANK-1:0]  bank_blocked
);

    word_flags_t        flags;
    logic [NBANK-1:0]   load_vec;
    logic [CNT_W-1:0]   load_val;

    assign flags = '{vld: wd_vld, last: wd_last, gap: wd_gap};

    tat_arm_decode #(.NBANK(NBANK), .DLY_W(DLY_W)) i_decode (
        .flags    (flags),
        .bank     (wd_bank),
        .dly      (dly_cfg),
        .load_vec (load_vec),
        .load_val (load_val)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        tat_bank_cnt #(.CNT_W(CNT_W)) i_cnt (
            .clk      (clk),
            .rst      (rst),
            .load     (load_vec[g]),
            .load_val (load_val),
            .busy     (bank_blocked[g])
        );
    end

    tat_start_gate #(.NBANK(NBANK)) i_gate (
        .rq_vld  (rq_vld),
        .rq_bank (rq_bank),
        .blocked (bank_blocked),
        .rq_go   (rq_go)
    );

endmodule

// File: rtl/tat_gap_checker.sv
module tat_gap_checker #(
    parameter int unsigned NBANK  = 4,
    parameter int unsigned DLY_W  = 2,
    localparam int unsigned BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic [DLY_W-1:0]  dly_cfg,
    input logic              wd_vld,
    input logic              wd_last,
    input logic              wd_gap,
    input logic [BANK_W-1:0] wd_bank,
    input logic              rq_vld,
    input logic [BANK_W-1:0] rq_bank,
    input logic              rq_go,
    input logic [NBANK-1:0]  bank_blocked
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (bank_blocked == '0));

    assert_ignored_word_R2: assert property (@(posedge clk) disable iff (rst)
        (wd_vld && !(wd_last && wd_gap) && !bank_blocked[wd_bank])
        |=> !bank_blocked[$past(wd_bank)]);

    assert_armed_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        (wd_vld && wd_last && wd_gap) |=> bank_blocked[$past(wd_bank)]);

    assert_no_go_blocked_R8: assert property (@(posedge clk) disable iff (rst)
        rq_go |-> (rq_vld && !bank_blocked[rq_bank]));

    for (genvar g = 0; g < NBANK; g++) begin : g_chk
        // R5: a bank becomes blocked only when it is the armed bank
        assert_own_bank_R5: assert property (@(posedge clk) disable iff (rst)
            $rose(bank_blocked[g]) |->
                $past(wd_vld && wd_last && wd_gap && (wd_bank == BANK_W'(g))));
    end

endmodule

bind bank_gap_timer tat_gap_checker #(.NBANK(NBANK), .DLY_W(DLY_W)) i_gap_chk (
    .clk          (clk),
    .rst          (rst),
    .dly_cfg      (dly_cfg),
    .wd_vld       (wd_vld),
    .wd_last      (wd_last),
    .wd_gap       (wd_gap),
    .wd_bank      (wd_bank),
    .rq_vld       (rq_vld),
    .rq_bank      (rq_bank),
    .rq_go        (rq_go),
    .bank_blocked (bank_blocked)
);

// File: tb/test_bank_gap_timer.sv
module test_bank_gap_timer;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] dly_cfg;
    logic       wd_vld, wd_last, wd_gap;
    logic [1:0] wd_bank;
    logic       rq_vld;
    logic [1:0] rq_bank;
    logic       rq_go;
    logic [3:0] bank_blocked;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    bank_gap_timer i_bank_gap_timer (
        .clk(clk), .rst(rst), .dly_cfg(dly_cfg),
        .wd_vld(wd_vld), .wd_last(wd_last), .wd_gap(wd_gap), .wd_bank(wd_bank),
        .rq_vld(rq_vld), .rq_bank(rq_bank), .rq_go(rq_go),
        .bank_blocked(bank_blocked)
    );

    typedef struct packed {
        logic [1:0] dly;
        logic [1:0] bank;
        logic       last;
        logic       gap;
        logic [2:0] exp_len;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 2'd0, 1'b1, 1'b1, 3'd1},   // R4
        '{2'd1, 2'd1, 1'b1, 1'b1, 3'd2},   // R4
        '{2'd2, 2'd2, 1'b1, 1'b1, 3'd3},   // R4
        '{2'd3, 2'd3, 1'b1, 1'b1, 3'd4},   // R4
        '{2'd3, 2'd1, 1'b0, 1'b1, 3'd0},   // R2
        '{2'd2, 2'd2, 1'b1, 1'b0, 3'd0},   // R3
        '{2'd1, 2'd3, 1'b1, 1'b1, 3'd2},   // R4
        '{2'd0, 2'd2, 1'b0, 1'b0, 3'd0}    // R2
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic word(input logic [1:0] b, input logic l, input logic g, input logic [1:0] d);
        wd_vld = 1'b1; wd_last = l; wd_gap = g; wd_bank = b; dly_cfg = d;
        @(negedge clk);
        wd_vld = 1'b0; wd_last = 1'b0; wd_gap = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // counts blocked cycles of bank b starting at the current negedge
    task automatic count_blocked(input logic [1:0] b, output int len, output bit other_hit);
        len = 0; other_hit = 0;
        for (int k = 0; k < 6; k++) begin
            if (bank_blocked[b]) len++;
            for (int j = 0; j < 4; j++)
                if (j != int'(b) && bank_blocked[j]) other_hit = 1;
            @(negedge clk);
        end
    endtask

    initial begin
        int len;
        bit oth;
        int wait_n;
        rst = 1'b1; dly_cfg = 2'd0;
        wd_vld = 0; wd_last = 0; wd_gap = 0; wd_bank = 0;
        rq_vld = 0; rq_bank = 0;
        idle(3);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(bank_blocked == 4'b0, "R1 blocked after reset", bank_blocked, 0);
        rq_vld = 1'b1; rq_bank = 2'd2; #1;
        check(rq_go == 1'b1, "R1 request starts after reset", rq_go, 1);
        rq_vld = 1'b0;

        // Vector walk: R2 R3 R4 R5
        foreach (VECS[i]) begin
            word(VECS[i].bank, VECS[i].last, VECS[i].gap, VECS[i].dly);
            count_blocked(VECS[i].bank, len, oth);
            check(len == int'(VECS[i].exp_len), "R4/R2/R3 gap length", len, VECS[i].exp_len);
            check(!oth, "R5 other bank untouched", oth, 0);
        end

        // R5: request to another bank starts while one bank is blocked
        word(2'd0, 1'b1, 1'b1, 2'd3);
        rq_vld = 1'b1; rq_bank = 2'd1; #1;
        check(rq_go == 1'b1, "R5 other bank starts at once", rq_go, 1);
        rq_bank = 2'd0; #1;
        check(rq_go == 1'b0, "R8 blocked bank held", rq_go, 0);
        rq_vld = 1'b0;
        idle(6);

        // R6: overlapping countdowns
        word(2'd0, 1'b1, 1'b1, 2'd3);   // bank0: 4 cycles
        word(2'd2, 1'b1, 1'b1, 2'd0);   // bank2: 1 cycle
        check(bank_blocked == 4'b0101, "R6 both banks blocked", bank_blocked, 5);
        @(negedge clk);
        check(bank_blocked == 4'b0001, "R6 short bank cleared first", bank_blocked, 1);
        idle(6);

        // R7: re-arm reloads
        word(2'd1, 1'b1, 1'b1, 2'd3);
        idle(2);
        word(2'd1, 1'b1, 1'b1, 2'd3);
        count_blocked(2'd1, len, oth);
        check(len == 4, "R7 reload to full gap", len, 4);

        // R9: setting captured at arming
        word(2'd3, 1'b1, 1'b1, 2'd3);
        dly_cfg = 2'd0;
        count_blocked(2'd3, len, oth);
        check(len == 4, "R9 setting change ignored", len, 4);

        // R8: held request starts first cycle after counter reaches zero
        word(2'd1, 1'b1, 1'b1, 2'd1);   // 2 blocked cycles
        rq_vld = 1'b1; rq_bank = 2'd1;
        wait_n = 0;
        for (int k = 0; k < 8; k++) begin
            #1;
            if (rq_go) break;
            wait_n++;
            @(negedge clk);
        end
        check(wait_n == 2, "R8 held request wait cycles", wait_n, 2);
        check(bank_blocked[1] == 1'b0, "R8 bank free at start", bank_blocked[1], 0);
        rq_vld = 1'b0;

        // R1: reset clears a running counter
        word(2'd2, 1'b1, 1'b1, 2'd3);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(bank_blocked == 4'b0, "R1 reset clears counters", bank_blocked, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule